// File: doc/BRIEF.md
# Tracking-Channel Code Settings Preset Controller

This block governs how new code-generator settings reach one satellite tracking channel. Four settings are covered: the spreading-code selection, the epoch count, the slew amount and the code oscillator phase. Software reaches them through a small write port. When the channel is in preset mode, writes to these four settings land in shadow registers. The channel keeps running on the values it already holds. Only a write to the epoch register arms the preset, so that write has to come last. On the next measurement tick, all four shadow values are loaded into the code generator in the same cycle. The code phase is overwritten whatever its earlier value was.

The code and carrier oscillator increment registers never go through the shadow path. A write to either one reaches its load port on the next cycle, in either mode. A tick never touches the carrier side in any way. In update mode, each settings write goes straight to its load port. After a preset is applied, the armed flag clears and a done flag is raised. The done flag stays high until software acknowledges it with a status-read strobe. The code generator and the oscillators are outside this block and appear only as load strobes with value buses.

Top module: `chan_preset_top`

## Requirements
- R1: After reset, presetMode, presetArmed, presetDone and every load strobe are 0. A write to address 0 sets presetMode to wrData[0] from the next cycle on, where 1 means preset mode and 0 means update mode.
- R2: In preset mode, writes to address 0 (code selection in wrData[SEL_W:1]), address 1 (phase), address 2 (slew) and address 3 (epoch) raise no load strobe.
- R3: Writes to addresses 0, 1 and 2 never change presetArmed. An epoch write in preset mode sets presetArmed from the next cycle.
- R4: A tick sampled while presetArmed is 1 pulses codeSelLoad, epochLoad, slewLoad and phaseLoad together for one cycle, starting in the next cycle. The value buses carry the latest shadow values, and presetArmed returns to 0.
- R5: presetDone rises in the same cycle as the R4 load pulses. It stays high until a statusRd is sampled. A statusRd sampled in the same cycle as an applying tick leaves presetDone high.
- R6: A second epoch write before the tick re-arms the preset. The apply then uses the latest shadow values, and only one apply happens for that arming.
- R7: A write to address 4 (code increment, wrData[INC_W-1:0]) or address 5 (carrier increment) pulses codeIncLoad or carrIncLoad in the next cycle with the written value. This holds in either mode and while armed.
- R8: A tick never pulses carrIncLoad and never changes carrInc.
- R9: In update mode, a write to address 0, 1, 2 or 3 pulses only its own load strobe in the next cycle, carrying the written field.
- R10: A tick while presetArmed is 0 raises no load strobe. A tick in the same cycle as an epoch write applies the earlier arming, with the shadow values from before that write, and presetArmed stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address (0 control, 1 phase, 2 slew, 3 epoch, 4 code increment, 5 carrier increment) |
| wrData | input | DATA_W | Write data |
| tic | input | 1 | Measurement tick pulse |
| statusRd | input | 1 | Acknowledges the done flag |
| presetMode | output | 1 | 1 = preset mode, 0 = update mode |
| presetArmed | output | 1 | Preset waits for the next tick |
| presetDone | output | 1 | Preset has been applied and not yet acknowledged |
| codeSelLoad | output | 1 | Code selection load strobe |
| codeSel | output | SEL_W | Code selection value |
| epochLoad | output | 1 | Epoch count load strobe |
| epochVal | output | EPOCH_W | Epoch count value |
| slewLoad | output | 1 | Slew load strobe |
| slewVal | output | SLEW_W | Slew value |
| phaseLoad | output | 1 | Code oscillator phase load strobe |
| phaseVal | output | PHASE_W | Code oscillator phase value |
| codeIncLoad | output | 1 | Code oscillator increment load strobe |
| codeInc | output | INC_W | Code oscillator increment |
| carrIncLoad | output | 1 | Carrier oscillator increment load strobe |
| carrInc | output | INC_W | Carrier oscillator increment |

## Verification
The bench builds the block with DATA_W=16, SEL_W=5, EPOCH_W=12, SLEW_W=9, PHASE_W=10 and INC_W=14. With these fields narrower than the data word, the all-ones write patterns show both the top of each field and the truncation of the bits above it. The narrow fields also keep full-scale shadow values short enough to check by eye against the load buses. The scoreboard order covers the single-cycle cases: a tick colliding with an epoch write, a tick colliding with a status read, and an increment write while armed.

// File: rtl/chan_preset_pkg.sv
package chan_preset_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PHASE    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_SLEW     = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_EPOCH    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CODE_INC = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CARR_INC = 3'd5;

  // Strobes from control to datapath, one bit per action this cycle
  typedef struct packed {
    logic shSel;
    logic shPhase;
    logic shSlew;
    logic shEpoch;
    logic apply;
    logic dirSel;
    logic dirPhase;
    logic dirSlew;
    logic dirEpoch;
    logic codeIncWr;
    logic carrIncWr;
  } presetStrobes_t;
endpackage

// File: rtl/chan_preset_ctrl.sv
module chan_preset_ctrl
  import chan_preset_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              modeBit,
  input  logic              tic,
  input  logic              statusRd,
  output presetStrobes_t    strb,
  output logic              modeQ,
  output logic              armedQ,
  output logic              doneQ
);
  logic isCtrl, isPhase, isSlew, isEpoch;
  logic effMode;

  assign isCtrl  = wrEn && (wrAddr == ADDR_CTRL);
  assign isPhase = wrEn && (wrAddr == ADDR_PHASE);
  assign isSlew  = wrEn && (wrAddr == ADDR_SLEW);
  assign isEpoch = wrEn && (wrAddr == ADDR_EPOCH);

  // A control write picks the mode for its own selection field
  assign effMode = isCtrl ? modeBit : modeQ;

  always_comb begin
    strb           = '0;
    strb.shSel     = isCtrl  &&  effMode;
    strb.shPhase   = isPhase &&  effMode;
    strb.shSlew    = isSlew  &&  effMode;
    strb.shEpoch   = isEpoch &&  effMode;
    strb.dirSel    = isCtrl  && !effMode;
    strb.dirPhase  = isPhase && !effMode;
    strb.dirSlew   = isSlew  && !effMode;
    strb.dirEpoch  = isEpoch && !effMode;
    strb.apply     = tic && armedQ;
    strb.codeIncWr = wrEn && (wrAddr == ADDR_CODE_INC);
    strb.carrIncWr = wrEn && (wrAddr == ADDR_CARR_INC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= 1'b0;
      armedQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      if (isCtrl) modeQ <= modeBit;
      // A fresh epoch write re-arms even when a tick consumes the old arming
      if (strb.shEpoch)    armedQ <= 1'b1;
      else if (strb.apply) armedQ <= 1'b0;
      if (strb.apply)      doneQ <= 1'b1;
      else if (statusRd)   doneQ <= 1'b0;
    end
  end
endmodule

// File: rtl/chan_preset_dp.sv
module chan_preset_dp
  import chan_preset_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SEL_W   = 6,
  parameter int unsigned EPOCH_W = 16,
  parameter int unsigned SLEW_W  = 11,
  parameter int unsigned PHASE_W = 10,
  parameter int unsigned INC_W   = 26
) (
  input  logic               clk,
  input  logic               rstN,
  input  presetStrobes_t     strb,
  input  logic [DATA_W-1:0]  wrData,
  output logic               codeSelLoad,
  output logic [SEL_W-1:0]   codeSel,
  output logic               epochLoad,
  output logic [EPOCH_W-1:0] epochVal,
  output logic               slewLoad,
  output logic [SLEW_W-1:0]  slewVal,
  output logic               phaseLoad,
  output logic [PHASE_W-1:0] phaseVal,
  output logic               codeIncLoad,
  output logic [INC_W-1:0]   codeInc,
  output logic               carrIncLoad,
  output logic [INC_W-1:0]   carrInc
);
  localparam int unsigned SEL_LSB = 1;
  localparam int unsigned SEL_MSB = SEL_LSB + SEL_W - 1;

  logic [SEL_W-1:0]   selField;
  logic [EPOCH_W-1:0] epochField;
  logic [SLEW_W-1:0]  slewField;
  logic [PHASE_W-1:0] phaseField;
  logic [INC_W-1:0]   incField;
  logic               unusedData;

  assign selField   = wrData[SEL_MSB:SEL_LSB];
  assign epochField = wrData[EPOCH_W-1:0];
  assign slewField  = wrData[SLEW_W-1:0];
  assign phaseField = wrData[PHASE_W-1:0];
  assign incField   = wrData[INC_W-1:0];
  assign unusedData = ^wrData;

  logic [SEL_W-1:0]   shSelQ;
  logic [EPOCH_W-1:0] shEpochQ;
  logic [SLEW_W-1:0]  shSlewQ;
  logic [PHASE_W-1:0] shPhaseQ;

  // Shadow registers: written on staged writes, after any same-cycle apply reads them
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shSelQ   <= '0;
      shEpochQ <= '0;
      shSlewQ  <= '0;
      shPhaseQ <= '0;
    end else begin
      if (strb.shSel)   shSelQ   <= selField;
      if (strb.shEpoch) shEpochQ <= epochField;
      if (strb.shSlew)  shSlewQ  <= slewField;
      if (strb.shPhase) shPhaseQ <= phaseField;
    end
  end

  // Load ports: a tick apply has priority over a direct write to the same field
  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeSelLoad <= 1'b0;
      epochLoad   <= 1'b0;
      slewLoad    <= 1'b0;
      phaseLoad   <= 1'b0;
      codeIncLoad <= 1'b0;
      carrIncLoad <= 1'b0;
      codeSel     <= '0;
      epochVal    <= '0;
      slewVal     <= '0;
      phaseVal    <= '0;
      codeInc     <= '0;
      carrInc     <= '0;
    end else begin
      codeSelLoad <= strb.apply | strb.dirSel;
      epochLoad   <= strb.apply | strb.dirEpoch;
      slewLoad    <= strb.apply | strb.dirSlew;
      phaseLoad   <= strb.apply | strb.dirPhase;
      codeIncLoad <= strb.codeIncWr;
      carrIncLoad <= strb.carrIncWr;
      if (strb.apply)         codeSel  <= shSelQ;
      else if (strb.dirSel)   codeSel  <= selField;
      if (strb.apply)         epochVal <= shEpochQ;
      else if (strb.dirEpoch) epochVal <= epochField;
      if (strb.apply)         slewVal  <= shSlewQ;
      else if (strb.dirSlew)  slewVal  <= slewField;
      if (strb.apply)         phaseVal <= shPhaseQ;
      else if (strb.dirPhase) phaseVal <= phaseField;
      if (strb.codeIncWr)     codeInc  <= incField;
      if (strb.carrIncWr)     carrInc  <= incField;
    end
  end
endmodule

// File: rtl/chan_preset_top.sv
module chan_preset_top
  import chan_preset_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SEL_W   = 6,
  parameter int unsigned EPOCH_W = 16,
  parameter int unsigned SLEW_W  = 11,
  parameter int unsigned PHASE_W = 10,
  parameter int unsigned INC_W   = 26
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               tic,
  input  logic               statusRd,
  output logic               presetMode,
  output logic               presetArmed,
  output logic               presetDone,
  output logic               codeSelLoad,
  output logic [SEL_W-1:0]   codeSel,
  output logic               epochLoad,
  output logic [EPOCH_W-1:0] epochVal,
  output logic               slewLoad,
  output logic [SLEW_W-1:0]  slewVal,
  output logic               phaseLoad,
  output logic [PHASE_W-1:0] phaseVal,
  output logic               codeIncLoad,
  output logic [INC_W-1:0]   codeInc,
  output logic               carrIncLoad,
  output logic [INC_W-1:0]   carrInc
);
  presetStrobes_t strb;

  chan_preset_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .modeBit  (wrData[0]),
    .tic      (tic),
    .statusRd (statusRd),
    .strb     (strb),
    .modeQ    (presetMode),
    .armedQ   (presetArmed),
    .doneQ    (presetDone)
  );

  chan_preset_dp #(
    .DATA_W (DATA_W), .SEL_W (SEL_W), .EPOCH_W (EPOCH_W),
    .SLEW_W (SLEW_W), .PHASE_W (PHASE_W), .INC_W (INC_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .codeSelLoad (codeSelLoad),
    .codeSel     (codeSel),
    .epochLoad   (epochLoad),
    .epochVal    (epochVal),
    .slewLoad    (slewLoad),
    .slewVal     (slewVal),
    .phaseLoad   (phaseLoad),
    .phaseVal    (phaseVal),
    .codeIncLoad (codeIncLoad),
    .codeInc     (codeInc),
    .carrIncLoad (carrIncLoad),
    .carrInc     (carrInc)
  );
endmodule

// File: rtl/chan_preset_chk.sv
module chan_preset_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned INC_W  = 26
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              tic,
  input logic              statusRd,
  input logic              presetMode,
  input logic              presetArmed,
  input logic              presetDone,
  input logic              codeSelLoad,
  input logic              epochLoad,
  input logic              slewLoad,
  input logic              phaseLoad,
  input logic              codeIncLoad,
  input logic [INC_W-1:0]  codeInc,
  input logic              carrIncLoad,
  input logic [INC_W-1:0]  carrInc
);
  logic wrCtrl, wrEpoch, wrCode, wrCarr, anyCodeLoad;
  assign wrCtrl      = wrEn && (wrAddr == 3'd0);
  assign wrEpoch     = wrEn && (wrAddr == 3'd3);
  assign wrCode      = wrEn && (wrAddr == 3'd4);
  assign wrCarr      = wrEn && (wrAddr == 3'd5);
  assign anyCodeLoad = codeSelLoad || epochLoad || slewLoad || phaseLoad;

  a_r1_mode_follows: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> presetMode == $past(wrData[0]));

  a_r2_staged_quiet: assert property (@(posedge clk) disable iff (!rstN)
    presetMode && !wrCtrl && !(presetArmed && tic) |=> !anyCodeLoad);

  a_r3_no_arm_without_epoch: assert property (@(posedge clk) disable iff (!rstN)
    !presetArmed && !wrEpoch |=> !presetArmed);

  a_r4_apply_loads: assert property (@(posedge clk) disable iff (!rstN)
    presetArmed && tic |=> codeSelLoad && epochLoad && slewLoad && phaseLoad);

  a_r4_armed_clears: assert property (@(posedge clk) disable iff (!rstN)
    presetArmed && tic && !wrEpoch |=> !presetArmed);

  a_r5_done_on_apply: assert property (@(posedge clk) disable iff (!rstN)
    presetArmed && tic |=> presetDone);

  a_r5_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    presetDone && !statusRd |=> presetDone);

  a_r7_code_inc_now: assert property (@(posedge clk) disable iff (!rstN)
    wrCode |=> codeIncLoad && (codeInc == $past(wrData[INC_W-1:0])));

  a_r8_carrier_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrCarr |=> !carrIncLoad && $stable(carrInc));

  a_r10_idle_tic: assert property (@(posedge clk) disable iff (!rstN)
    !presetArmed && !wrEn |=> !anyCodeLoad);
endmodule

bind chan_preset_top chan_preset_chk #(.DATA_W(DATA_W), .INC_W(INC_W)) uChk (.*);

// File: tb/tb_chan_preset_top.sv
module tb_chan_preset_top;
  localparam int DATA_W = 16, SEL_W = 5, EPOCH_W = 12, SLEW_W = 9, PHASE_W = 10, INC_W = 14;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, tic = 1'b0, statusRd = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic presetMode, presetArmed, presetDone;
  logic codeSelLoad, epochLoad, slewLoad, phaseLoad, codeIncLoad, carrIncLoad;
  logic [SEL_W-1:0] codeSel;
  logic [EPOCH_W-1:0] epochVal;
  logic [SLEW_W-1:0] slewVal;
  logic [PHASE_W-1:0] phaseVal;
  logic [INC_W-1:0] codeInc, carrInc;

  chan_preset_top #(.DATA_W(DATA_W), .SEL_W(SEL_W), .EPOCH_W(EPOCH_W),
    .SLEW_W(SLEW_W), .PHASE_W(PHASE_W), .INC_W(INC_W)) dut (.*);

  always #10 clk = ~clk;

  typedef struct { int kind; int val; string req; } item_t;
  item_t expQ[$];
  int checks = 0, failures = 0;
  bit finished = 0;

  // Bench model of the requirements
  bit mMode = 0, mArmed = 0, mDone = 0;
  int shSel = 0, shEpoch = 0, shSlew = 0, shPhase = 0;

  function automatic int fld(int v, int w);
    return v & ((1 << w) - 1);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(int kind, int val, string req);
    item_t it;
    it.kind = kind; it.val = val; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: kinds 0 sel, 1 epoch, 2 slew, 3 phase, 4 code inc, 5 carrier inc
  task automatic see(int kind, int val);
    item_t it;
    checks++;
    if (expQ.size() == 0) begin
      failures++;
      $display("FAIL R2/R10 unexpected load kind=%0d actual=%0d expected=none", kind, val);
    end else begin
      it = expQ.pop_front();
      if (it.kind != kind || it.val != val) begin
        failures++;
        $display("FAIL %s kind actual=%0d expected=%0d value actual=%0d expected=%0d",
                 it.req, kind, it.kind, val, it.val);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (codeSelLoad) see(0, int'(codeSel));
      if (epochLoad)   see(1, int'(epochVal));
      if (slewLoad)    see(2, int'(slewVal));
      if (phaseLoad)   see(3, int'(phaseVal));
      if (codeIncLoad) see(4, int'(codeInc));
      if (carrIncLoad) see(5, int'(carrInc));
    end
  end

  // Driver: one stimulus cycle, expectations pushed, then status compared
  task automatic step(bit we, int addr, int data, bit t, bit rd, string req);
    bit apply, eff;
    int d;
    d = fld(data, DATA_W);
    apply = t && mArmed;
    if (apply) begin
      push(0, shSel, "R4 sel"); push(1, shEpoch, "R4 epoch");
      push(2, shSlew, "R4 slew"); push(3, shPhase, "R4 phase");
    end
    eff = (we && addr == 0) ? d[0] : mMode;
    if (we) begin
      case (addr)
        0: begin mMode = d[0];
             if (eff) shSel = fld(d >> 1, SEL_W); else push(0, fld(d >> 1, SEL_W), "R9 sel"); end
        1: if (eff) shPhase = fld(d, PHASE_W); else push(3, fld(d, PHASE_W), "R9 phase");
        2: if (eff) shSlew = fld(d, SLEW_W); else push(2, fld(d, SLEW_W), "R9 slew");
        3: if (eff) shEpoch = fld(d, EPOCH_W); else push(1, fld(d, EPOCH_W), "R9 epoch");
        4: push(4, fld(d, INC_W), "R7 code inc");
        5: push(5, fld(d, INC_W), "R7 carrier inc");
        default: ;
      endcase
    end
    if (we && addr == 3 && eff) mArmed = 1; else if (apply) mArmed = 0;
    if (apply) mDone = 1; else if (rd) mDone = 0;
    @(negedge clk);
    wrEn = we; wrAddr = 3'(addr); wrData = DATA_W'(data); tic = t; statusRd = rd;
    @(negedge clk);
    wrEn = 0; tic = 0; statusRd = 0;
    check({req, " R1 mode"}, int'(presetMode), int'(mMode));
    check({req, " R3 armed"}, int'(presetArmed), int'(mArmed));
    check({req, " R5 done"}, int'(presetDone), int'(mDone));
  endtask

  initial begin
    #(20 * 5000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int carrSeen;
    repeat (3) @(negedge clk);
    check("R1 reset mode", int'(presetMode), 0);
    check("R1 reset armed", int'(presetArmed), 0);
    check("R1 reset done", int'(presetDone), 0);
    rstN = 1;
    @(negedge clk);
    check("R1 no strobe after reset", int'(codeSelLoad | epochLoad | phaseLoad | carrIncLoad), 0);

    // R9 update mode: each write lands directly
    step(1, 0, (7 << 1) | 0, 0, 0, "R9");
    step(1, 1, 300, 0, 0, "R9");
    step(1, 2, 77, 0, 0, "R9");
    step(1, 3, 1234, 0, 0, "R9");
    step(0, 0, 0, 1, 0, "R10 tic unarmed");

    // R1/R2/R3 preset mode: staged writes, only epoch arms
    step(1, 0, (19 << 1) | 1, 0, 0, "R2 ctrl staged");
    step(1, 1, 555, 0, 0, "R2 phase staged");
    step(1, 2, 201, 0, 0, "R3 slew no arm");
    step(1, 4, 9999, 0, 0, "R7 code inc preset mode");
    step(1, 3, 3000, 0, 0, "R3 epoch arms");
    step(1, 5, 4321, 0, 0, "R7 carrier inc while armed");
    carrSeen = 4321;
    step(0, 0, 0, 1, 0, "R4 apply");
    check("R8 carrier value after tic", int'(carrInc), carrSeen);
    step(0, 0, 0, 1, 0, "R6 second tic no apply");
    step(0, 0, 0, 0, 1, "R5 status read");

    // R6 re-arm uses latest shadow values
    step(1, 1, 100, 0, 0, "R6");
    step(1, 3, 11, 0, 0, "R6 first arm");
    step(1, 1, 1023, 0, 0, "R6");
    step(1, 3, 4095, 0, 0, "R6 re-arm");
    step(0, 0, 0, 1, 1, "R5 read with apply");
    step(0, 0, 0, 0, 1, "R5 read clears");

    // R10 tic with epoch write: old arming applies, new one stays armed
    step(1, 2, 'h7FFF, 0, 0, "R6 slew full scale");
    step(1, 3, 500, 0, 0, "R10 arm");
    step(1, 3, 600, 1, 0, "R10 tic with epoch write");
    step(0, 0, 0, 1, 0, "R10 later apply");
    check("R8 carrier value unchanged", int'(carrInc), carrSeen);

    // Truncation of upper data bits, back to update mode
    step(1, 0, 'hFFFE, 0, 0, "R9 sel full scale");
    step(1, 3, 'hFFFF, 0, 0, "R9 epoch full scale");
    step(1, 4, 'hFFFF, 0, 0, "R7 code inc full scale");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule